// File: doc/BRIEF.md
# Hashed Inverted Translation Table

This block translates a virtual page number into a physical address. It uses a table that has one slot per physical frame, not one per virtual page. The requested page number is folded by an XOR hash into a slot index. The slot holds a presence flag and the full virtual page number that owns the frame. The frame number is never stored, because it is the slot index itself.

A lookup presented in one cycle gives its answer in the next cycle. The answer is exactly one of three outcomes:

- **hit**: the stored tag equals the request and the slot is marked present. The physical address is the slot index placed above the unchanged page offset.
- **fault**: the tag matches but the slot is marked absent.
- **miss**: the tag differs. Software or a walker then consults the complete mapping and installs the entry.

A single load port writes an entry, tag and present flag together, into the slot that its own page number hashes to. The load port never spills into a second slot.

Top module: `ipt_lookup`

## Requirements
- R1: While reset is high and in the first cycle after it, `rsp_valid` is 0. Reset marks every slot absent. Tags start as zero, so after reset a lookup of page 0x00000 reports fault and a lookup of page 0x12345 reports miss.
- R2: The slot index of a 20-bit page number v with 256 frames is v[7:0] ^ v[15:8] ^ {4'b0000, v[19:16]}. The same index is used for lookups and for loads.
- R3: A lookup of an installed, present page reports `rsp_hit`. `rsp_paddr` is then {index, offset}, with the offset in bits 11:0 and the 8-bit index in bits 19:12.
- R4: A lookup whose tag matches a slot marked absent reports `rsp_fault`.
- R5: A lookup of a page whose index is shared by a different installed page (for example 0x00067 against 0x12345) reports `rsp_miss`.
- R6: When `rsp_valid` is 1, exactly one of `rsp_hit`, `rsp_fault` and `rsp_miss` is 1. When `rsp_valid` is 0, all three are 0.
- R7: `rsp_valid` is 1 in exactly the cycle after a cycle with `req_valid` high. Back-to-back requests each give their own answer, in order.
- R8: A load in the same cycle as a lookup of the same slot does not affect that lookup. It takes effect for the next lookup.
- R9: A load replaces the whole slot, so the page previously held there now reports miss.
- R10: Whenever `rsp_hit` is 0, `rsp_paddr` is zero.
- R11: A reset after installing entries makes their lookups report fault, not hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vpn | input | 20 | Virtual page number to translate |
| req_off | input | 12 | Page offset carried to the result |
| ld_en | input | 1 | Install strobe |
| ld_vpn | input | 20 | Page number to install (also selects the slot) |
| ld_valid | input | 1 | Present flag written with the entry |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_hit | output | 1 | Translation found and present |
| rsp_fault | output | 1 | Tag matched but entry absent |
| rsp_miss | output | 1 | Tag differs; consult the full mapping |
| rsp_paddr | output | 20 | {frame, offset} on a hit, else zero |

## Verification
A wrong index would first appear as a miss on a page that was just installed, or as a hit whose frame field disagrees with the XOR fold. Either shows one cycle after the lookup. A wrong present flag or a stale tag appears as a fault or a hit where the other is expected, on the first lookup of that slot. Read and write ordering faults, such as a load bypassing into the same-cycle lookup, are exposed by issuing both in one cycle. Aliasing pages that share an index show whether the tag compare, rather than the index alone, decides the outcome.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  typedef enum logic [1:0] {
    RES_NONE  = 2'd0,
    RES_HIT   = 2'd1,
    RES_FAULT = 2'd2,
    RES_MISS  = 2'd3
  } lookup_res_e;
endpackage

// File: rtl/ipt_hash.sv
// Folds a page number into an index by XOR of consecutive index-wide slices.
module ipt_hash #(
  parameter int VPN_W = 20,
  parameter int IDX_W = 8
) (
  input  logic [VPN_W-1:0] vpn,
  output logic [IDX_W-1:0] idx
);
  localparam int SLICES = (VPN_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W  = SLICES * IDX_W;

  logic [PAD_W-1:0] padded;
  logic [IDX_W-1:0] part [SLICES+1];

  assign padded  = PAD_W'(vpn);
  assign part[0] = '0;

  for (genvar g = 0; g < SLICES; g++) begin : g_fold
    assign part[g+1] = part[g] ^ padded[g*IDX_W +: IDX_W];
  end

  assign idx = part[SLICES];
endmodule

// File: rtl/ipt_tag_ram.sv
// Simple dual-port tag memory, read-first, registered read (block RAM style).
module ipt_tag_ram #(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int DW    = 20
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ipt_present_bits.sv
// Resettable present flags, one per slot, with registered read.
module ipt_present_bits #(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wbit,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic          rbit
);
  logic [DEPTH-1:0] flags;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
    end else if (we) begin
      flags[waddr] <= wbit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rbit <= 1'b0;
    end else if (re) begin
      rbit <= flags[raddr];
    end
  end
endmodule

// File: rtl/ipt_classify.sv
// Decides hit / fault / miss from the registered slot contents.
module ipt_classify
  import ipt_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int IDX_W = 8,
  parameter int OFF_W = 12
) (
  input  logic             busy,
  input  logic [VPN_W-1:0] want_vpn,
  input  logic [VPN_W-1:0] slot_tag,
  input  logic             slot_present,
  input  logic [IDX_W-1:0] slot_idx,
  input  logic [OFF_W-1:0] offset,
  output lookup_res_e      res,
  output logic [IDX_W+OFF_W-1:0] paddr
);
  always_comb begin
    res   = RES_NONE;
    paddr = '0;
    if (busy) begin
      if (slot_tag != want_vpn) begin
        res = RES_MISS;
      end else if (!slot_present) begin
        res = RES_FAULT;
      end else begin
        res   = RES_HIT;
        paddr = {slot_idx, offset};
      end
    end
  end
endmodule

// File: rtl/ipt_lookup.sv
module ipt_lookup
  import ipt_pkg::*;
#(
  parameter int FRAMES = 256,
  parameter int VPN_W  = 20,
  parameter int OFF_W  = 12,
  localparam int IDX_W = $clog2(FRAMES),
  localparam int PA_W  = IDX_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic [OFF_W-1:0] req_off,
  input  logic             ld_en,
  input  logic [VPN_W-1:0] ld_vpn,
  input  logic             ld_valid,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_fault,
  output logic             rsp_miss,
  output logic [PA_W-1:0]  rsp_paddr
);
  logic [IDX_W-1:0] rd_idx, wr_idx, idx_q;
  logic [VPN_W-1:0] vpn_q, tag_q;
  logic [OFF_W-1:0] off_q;
  logic             busy_q, present_q;
  lookup_res_e      res;

  ipt_hash #(.VPN_W(VPN_W), .IDX_W(IDX_W)) u_rd_hash (.vpn(req_vpn), .idx(rd_idx));
  ipt_hash #(.VPN_W(VPN_W), .IDX_W(IDX_W)) u_wr_hash (.vpn(ld_vpn),  .idx(wr_idx));

  ipt_tag_ram #(.DEPTH(FRAMES), .AW(IDX_W), .DW(VPN_W)) u_tags (
    .clk(clk), .we(ld_en), .waddr(wr_idx), .wdata(ld_vpn),
    .re(req_valid), .raddr(rd_idx), .rdata(tag_q)
  );

  ipt_present_bits #(.DEPTH(FRAMES), .AW(IDX_W)) u_flags (
    .clk(clk), .rst(rst), .we(ld_en), .waddr(wr_idx), .wbit(ld_valid),
    .re(req_valid), .raddr(rd_idx), .rbit(present_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      vpn_q  <= '0;
      off_q  <= '0;
      idx_q  <= '0;
    end else begin
      busy_q <= req_valid;
      if (req_valid) begin
        vpn_q <= req_vpn;
        off_q <= req_off;
        idx_q <= rd_idx;
      end
    end
  end

  ipt_classify #(.VPN_W(VPN_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_cls (
    .busy(busy_q), .want_vpn(vpn_q), .slot_tag(tag_q), .slot_present(present_q),
    .slot_idx(idx_q), .offset(off_q), .res(res), .paddr(rsp_paddr)
  );

  assign rsp_valid = busy_q;
  assign rsp_hit   = (res == RES_HIT);
  assign rsp_fault = (res == RES_FAULT);
  assign rsp_miss  = (res == RES_MISS);
endmodule

// File: rtl/ipt_lookup_chk.sv
module ipt_lookup_chk #(
  parameter int OFF_W = 12,
  parameter int PA_W  = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [OFF_W-1:0] req_off,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_fault,
  input logic             rsp_miss,
  input logic [PA_W-1:0]  rsp_paddr
);
  a_r7_answer_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  a_r6_one_outcome: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($countones({rsp_hit, rsp_fault, rsp_miss}) == 1));
  a_r6_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> ($countones({rsp_hit, rsp_fault, rsp_miss}) == 0));
  a_r10_zero_addr: assert property (@(posedge clk) disable iff (rst)
    !rsp_hit |-> (rsp_paddr == '0));
  a_r3_offset_kept: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_hit -> (rsp_paddr[OFF_W-1:0] == $past(req_off))));
endmodule

bind ipt_lookup ipt_lookup_chk #(.OFF_W(OFF_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_off(req_off),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
  .rsp_miss(rsp_miss), .rsp_paddr(rsp_paddr)
);

// File: tb/tb_ipt_lookup.sv
`timescale 1ns/1ps
module tb_ipt_lookup;
  localparam int K_NONE = 0, K_HIT = 1, K_FAULT = 2, K_MISS = 3;

  logic        clk = 0, rst = 1;
  logic        req_valid = 0, ld_en = 0, ld_valid = 0;
  logic [19:0] req_vpn = '0, ld_vpn = '0;
  logic [11:0] req_off = '0;
  logic        rsp_valid, rsp_hit, rsp_fault, rsp_miss;
  logic [19:0] rsp_paddr;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ipt_lookup dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vpn(req_vpn), .req_off(req_off),
    .ld_en(ld_en), .ld_vpn(ld_vpn), .ld_valid(ld_valid), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_miss(rsp_miss), .rsp_paddr(rsp_paddr)
  );

  function automatic logic [7:0] fold(input logic [19:0] v);
    return v[7:0] ^ v[15:8] ^ {4'h0, v[19:16]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Compare the visible response against an outcome kind.
  task automatic expect_rsp(input string req, input int kind, input logic [19:0] pa);
    check(req, {31'd0, rsp_valid}, {31'd0, kind != K_NONE});
    check(req, {29'd0, rsp_hit, rsp_fault, rsp_miss},
          {29'd0, kind == K_HIT, kind == K_FAULT, kind == K_MISS});
    check(req, {12'd0, rsp_paddr}, (kind == K_HIT) ? {12'd0, pa} : 32'd0);
  endtask

  task automatic install(input logic [19:0] v, input logic pres);
    @(negedge clk);
    ld_en = 1; ld_vpn = v; ld_valid = pres;
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic lookup(input string req, input logic [19:0] v, input logic [11:0] off,
                        input int kind);
    @(negedge clk);
    req_valid = 1; req_vpn = v; req_off = off;
    @(negedge clk);
    req_valid = 0;
    expect_rsp(req, kind, {fold(v), off});
  endtask

  task automatic t_reset_state();
    rst = 1;
    repeat (3) @(negedge clk);
    check("R1 during reset", {31'd0, rsp_valid}, 32'd0);
    rst = 0;
    @(negedge clk);
    check("R1 after reset", {31'd0, rsp_valid}, 32'd0);
    lookup("R1 page0 fault", 20'h00000, 12'h000, K_FAULT);
    lookup("R1 other miss", 20'h12345, 12'h001, K_MISS);
  endtask

  task automatic t_hits();
    install(20'h12345, 1);
    lookup("R3 hit", 20'h12345, 12'hABC, K_HIT);
    check("R2 index 12345", {24'd0, fold(20'h12345)}, 32'h67);
    install(20'hF0000, 1);
    lookup("R2 top nibble fold", 20'hF0000, 12'h5A5, K_HIT);
    install(20'hFEDCB, 1);
    lookup("R3 second hit", 20'hFEDCB, 12'hFFF, K_HIT);
  endtask

  task automatic t_alias_replace();
    lookup("R5 alias miss", 20'h00067, 12'h010, K_MISS);
    install(20'h00067, 1);
    lookup("R9 new owner hit", 20'h00067, 12'h020, K_HIT);
    lookup("R9 old owner miss", 20'h12345, 12'h030, K_MISS);
  endtask

  task automatic t_fault();
    install(20'h0ABCD, 0);
    lookup("R4 absent fault", 20'h0ABCD, 12'h111, K_FAULT);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    ld_en = 1; ld_vpn = 20'h0ABCD; ld_valid = 1;
    req_valid = 1; req_vpn = 20'h0ABCD; req_off = 12'h222;
    @(negedge clk);
    ld_en = 0; req_valid = 0;
    expect_rsp("R8 old contents", K_FAULT, 20'h0);
    lookup("R8 later sees load", 20'h0ABCD, 12'h333, K_HIT);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    req_valid = 1; req_vpn = 20'hFEDCB; req_off = 12'h444;
    @(negedge clk);
    expect_rsp("R7 first of pair", K_HIT, {fold(20'hFEDCB), 12'h444});
    req_vpn = 20'h55555; req_off = 12'h555;
    @(negedge clk);
    req_valid = 0;
    expect_rsp("R7 second of pair", K_MISS, 20'h0);
    @(negedge clk);
    expect_rsp("R7 idle after pair", K_NONE, 20'h0);
  endtask

  task automatic t_reset_clears();
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    lookup("R11 fault after reset", 20'h00067, 12'h666, K_FAULT);
    install(20'h00067, 1);
    lookup("R11 reinstall hit", 20'h00067, 12'h777, K_HIT);
  endtask

  initial begin
    t_reset_state();
    t_hits();
    t_alias_replace();
    t_fault();
    t_same_cycle();
    t_back_to_back();
    t_reset_clears();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule